// File: doc/BRIEF.md
# Variable-Length Instruction Field Decoder

This block takes a stream of instruction bytes, one byte for each accepted valid/ready transfer, and breaks each variable-length instruction into its fields. The fields are the legacy prefixes, an optional REX prefix, the opcode, the ModR/M and SIB bytes, the displacement and the immediate. When an instruction ends, the block presents a single record on its outputs. The record holds the prefix flags, the raw opcode, the split ModR/M and SIB fields, the displacement and immediate assembled little-endian, the byte count, and an error code. The record stays on the outputs until the consumer accepts it. Input is refused while a record is pending.

The supported opcode set is small:
- near return `C3`
- far return `CB`
- move of an immediate to a register or memory operand, `C7` with a Reg extension of `000`

The block does not compute effective addresses and does not handle multi-byte opcode escapes. Malformed input produces an error record. The decoder then restarts at the next byte.

Top module: `insn_field_decoder`

## Requirements
- R1: Opcodes `C3` and `CB` complete the instruction at the opcode byte. The record shows no ModR/M, no SIB, zero displacement and zero immediate. The length equals the number of prefix bytes plus one, and `out_err` is 0.
- R2: The legacy prefix groups are: lock/repeat `F0` `F2` `F3`; segment `2E` `36` `3E` `26` `64` `65`; operand size `66`; address size `67`. The record reports whether each group is present. For the lock/repeat and segment groups it also reports the prefix byte.
- R3: The block returns `out_err`=2 in any of three cases: a second prefix from a group that is already present, a second REX byte, or a legacy prefix after a REX byte. The length counts up to and including the offending byte.
- R4: Bytes `40`–`4F` are taken as REX only while `mode64` is high, and the record reports the low nibble. While `mode64` is low, these bytes are unsupported opcodes.
- R5: ModR/M is split into Mod (bits 7:6), Reg (bits 5:3) and R/M (bits 2:0). Opcode `C7` with a Reg value other than 000 gives `out_err`=1 at the ModR/M byte.
- R6: A SIB byte follows when R/M=100 and Mod≠11. It is split into Scale (bits 7:6), Index (bits 5:3) and Base (bits 2:0).
- R7: The displacement size depends on Mod and on R/M or the SIB Base:
  - Mod=01: one byte, sign-extended to 32 bits.
  - Mod=10: four bytes.
  - Mod=11: no displacement.
  - Mod=00: four bytes when R/M=101 without SIB, or when the SIB Base=101; otherwise no displacement.
- R8: Displacement and immediate bytes arrive least significant byte first. `C7` always carries a 4-byte immediate.
- R9: Any other opcode byte gives `out_err`=1, with the length counted through that byte.
- R10: An instruction still incomplete at its 15th byte gives `out_err`=3 with length 15. The following byte starts a new instruction.
- R11: `in_ready` is low while `out_valid` is high. The record stays unchanged until `out_ready` is sampled high.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode64 | input | 1 | Enables REX recognition |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte can be accepted |
| out_valid | output | 1 | Record pending |
| out_ready | input | 1 | Consumer accepts record |
| out_lock_rep | output | 1 | Lock/repeat prefix present |
| out_lock_rep_byte | output | 8 | Lock/repeat prefix value |
| out_seg_ovr | output | 1 | Segment prefix present |
| out_seg_byte | output | 8 | Segment prefix value |
| out_opsize | output | 1 | Operand-size prefix present |
| out_addrsize | output | 1 | Address-size prefix present |
| out_rex_valid | output | 1 | REX present |
| out_rex_bits | output | 4 | REX low nibble |
| out_opcode | output | 8 | Opcode byte |
| out_has_modrm | output | 1 | ModR/M present |
| out_mod | output | 2 | Mod field |
| out_reg | output | 3 | Reg field / opcode extension |
| out_rm | output | 3 | R/M field |
| out_has_sib | output | 1 | SIB present |
| out_scale | output | 2 | SIB Scale |
| out_index | output | 3 | SIB Index |
| out_base | output | 3 | SIB Base |
| out_disp | output | 32 | Assembled displacement |
| out_imm | output | 32 | Assembled immediate |
| out_len | output | 4 | Bytes in this instruction |
| out_err | output | 2 | 0 none, 1 unsupported opcode, 2 prefix rule, 3 too long |

## Verification
The bench builds the decoder with its default settings: a 15-byte length limit and 4-byte displacement and immediate fields. With a limit of 15, a legal-looking stream of four legacy prefixes, a REX byte, `C7`, ModR/M, SIB, a 4-byte displacement and a 4-byte immediate is longer than the limit. This puts the overlong case within reach of ordinary byte sequences. The 4-byte fields make every displacement size rule (none, sign-extended byte, four bytes) and the full little-endian assembly observable at the ports.

// File: rtl/idp_pkg.sv
package idp_pkg;
  parameter int LEN_LIMIT  = 15;
  parameter int LEN_W      = $clog2(LEN_LIMIT + 1);
  parameter int DISP_BYTES = 4;
  parameter int IMM_BYTES  = 4;
  parameter int DISP_W     = 8 * DISP_BYTES;
  parameter int IMM_W      = 8 * IMM_BYTES;
  parameter int CNT_W      = $clog2((DISP_BYTES > IMM_BYTES) ? DISP_BYTES : IMM_BYTES);
  parameter int DBW        = $clog2(DISP_BYTES + 1);

  parameter logic [7:0] OP_RET_NEAR = 8'hC3;
  parameter logic [7:0] OP_RET_FAR  = 8'hCB;
  parameter logic [7:0] OP_MOV_IMM  = 8'hC7;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_ILLEGAL = 2'd1,
    ERR_PREFIX  = 2'd2,
    ERR_LENGTH  = 2'd3
  } dec_err_e;

  typedef enum logic [2:0] {
    ST_PFX, ST_MODRM, ST_SIB, ST_DISP, ST_IMM
  } dec_state_e;

  typedef struct packed {
    logic              lock_rep;
    logic [7:0]        lock_rep_byte;
    logic              seg;
    logic [7:0]        seg_byte;
    logic              opsize;
    logic              addrsize;
    logic              rex;
    logic [3:0]        rex_bits;
    logic [7:0]        opcode;
    logic              has_modrm;
    logic [1:0]        mod;
    logic [2:0]        reg_f;
    logic [2:0]        rm;
    logic              has_sib;
    logic [1:0]        scale;
    logic [2:0]        index;
    logic [2:0]        base;
    logic [DISP_W-1:0] disp;
    logic [IMM_W-1:0]  imm;
    logic [LEN_W-1:0]  len;
    dec_err_e          err;
  } dec_rec_t;
endpackage

// File: rtl/idp_prefix_class.sv
module idp_prefix_class (
  input  logic [7:0] byte_i,
  input  logic       mode64_i,
  output logic [3:0] grp_o,
  output logic       rex_o
);
  // grp_o bit 0 lock/repeat, 1 segment, 2 operand size, 3 address size
  always_comb begin
    grp_o = 4'b0000;
    unique case (byte_i)
      8'hF0, 8'hF2, 8'hF3:                      grp_o = 4'b0001;
      8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65: grp_o = 4'b0010;
      8'h66:                                    grp_o = 4'b0100;
      8'h67:                                    grp_o = 4'b1000;
      default:                                  grp_o = 4'b0000;
    endcase
    rex_o = mode64_i && (byte_i[7:4] == 4'h4);
  end
endmodule

// File: rtl/idp_operand_layout.sv
module idp_operand_layout
  import idp_pkg::*;
(
  input  logic [1:0]     mod_i,
  input  logic [2:0]     rm_i,
  input  logic [2:0]     base_i,
  input  logic           sib_known_i,
  output logic           has_sib_o,
  output logic [DBW-1:0] disp_bytes_o
);
  always_comb begin
    has_sib_o = (rm_i == 3'b100) && (mod_i != 2'b11);
    unique case (mod_i)
      2'b00: begin
        if ((!has_sib_o && rm_i == 3'b101) ||
            (has_sib_o && sib_known_i && base_i == 3'b101))
          disp_bytes_o = DBW'(DISP_BYTES);
        else
          disp_bytes_o = '0;
      end
      2'b01:   disp_bytes_o = DBW'(1);
      2'b10:   disp_bytes_o = DBW'(DISP_BYTES);
      default: disp_bytes_o = '0;
    endcase
  end
endmodule

// File: rtl/insn_field_decoder.sv
module insn_field_decoder
  import idp_pkg::*;
#(
  parameter int MAX_LEN = LEN_LIMIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode64,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_lock_rep,
  output logic [7:0]        out_lock_rep_byte,
  output logic              out_seg_ovr,
  output logic [7:0]        out_seg_byte,
  output logic              out_opsize,
  output logic              out_addrsize,
  output logic              out_rex_valid,
  output logic [3:0]        out_rex_bits,
  output logic [7:0]        out_opcode,
  output logic              out_has_modrm,
  output logic [1:0]        out_mod,
  output logic [2:0]        out_reg,
  output logic [2:0]        out_rm,
  output logic              out_has_sib,
  output logic [1:0]        out_scale,
  output logic [2:0]        out_index,
  output logic [2:0]        out_base,
  output logic [DISP_W-1:0] out_disp,
  output logic [IMM_W-1:0]  out_imm,
  output logic [LEN_W-1:0]  out_len,
  output logic [1:0]        out_err
);
  localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] IMM_LAST = CNT_W'(IMM_BYTES - 1);

  dec_state_e       state_q, state_d;
  dec_rec_t         rec_q, rec_d;
  logic             vld_q, vld_d;
  logic [LEN_W-1:0] len_q, len_d, len_n;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DBW-1:0]   need_q, need_d;

  logic [3:0]       pfx_grp;
  logic             pfx_rex;
  logic [3:0]       seen_grp;
  logic             lay_sib;
  logic [DBW-1:0]   lay_disp;
  logic [1:0]       lay_mod;
  logic [2:0]       lay_rm;
  logic             take, fire, done;
  dec_err_e         err;

  idp_prefix_class u_pfx (
    .byte_i  (in_byte),
    .mode64_i(mode64),
    .grp_o   (pfx_grp),
    .rex_o   (pfx_rex)
  );

  assign lay_mod = (state_q == ST_SIB) ? rec_q.mod : in_byte[7:6];
  assign lay_rm  = (state_q == ST_SIB) ? rec_q.rm  : in_byte[2:0];

  idp_operand_layout u_lay (
    .mod_i       (lay_mod),
    .rm_i        (lay_rm),
    .base_i      (in_byte[2:0]),
    .sib_known_i (state_q == ST_SIB),
    .has_sib_o   (lay_sib),
    .disp_bytes_o(lay_disp)
  );

  assign in_ready = !vld_q;
  assign take     = in_valid && in_ready;
  assign fire     = vld_q && out_ready;
  assign len_n    = len_q + LEN_W'(1);
  assign seen_grp = {rec_q.addrsize, rec_q.opsize, rec_q.seg, rec_q.lock_rep};

  always_comb begin
    state_d = state_q;
    rec_d   = rec_q;
    vld_d   = vld_q;
    len_d   = len_q;
    cnt_d   = cnt_q;
    need_d  = need_q;
    done    = 1'b0;
    err     = ERR_NONE;
    if (fire) begin
      rec_d = '0;
      vld_d = 1'b0;
    end else if (take) begin
      unique case (state_q)
        ST_PFX: begin
          if (pfx_grp != 4'b0000) begin
            if (((pfx_grp & seen_grp) != 4'b0000) || rec_q.rex) err = ERR_PREFIX;
            if (pfx_grp[0]) begin rec_d.lock_rep = 1'b1; rec_d.lock_rep_byte = in_byte; end
            if (pfx_grp[1]) begin rec_d.seg = 1'b1; rec_d.seg_byte = in_byte; end
            if (pfx_grp[2]) rec_d.opsize = 1'b1;
            if (pfx_grp[3]) rec_d.addrsize = 1'b1;
          end else if (pfx_rex) begin
            if (rec_q.rex) err = ERR_PREFIX;
            rec_d.rex      = 1'b1;
            rec_d.rex_bits = in_byte[3:0];
          end else begin
            rec_d.opcode = in_byte;
            if (in_byte == OP_RET_NEAR || in_byte == OP_RET_FAR) begin
              done = 1'b1;
            end else if (in_byte == OP_MOV_IMM) begin
              rec_d.has_modrm = 1'b1;
              state_d         = ST_MODRM;
            end else begin
              err = ERR_ILLEGAL;
            end
          end
        end
        ST_MODRM: begin
          rec_d.mod   = in_byte[7:6];
          rec_d.reg_f = in_byte[5:3];
          rec_d.rm    = in_byte[2:0];
          cnt_d       = '0;
          need_d      = lay_disp;
          if (in_byte[5:3] != 3'b000) err = ERR_ILLEGAL;
          else if (lay_sib)           state_d = ST_SIB;
          else if (lay_disp != '0)    state_d = ST_DISP;
          else                        state_d = ST_IMM;
        end
        ST_SIB: begin
          rec_d.has_sib = 1'b1;
          rec_d.scale   = in_byte[7:6];
          rec_d.index   = in_byte[5:3];
          rec_d.base    = in_byte[2:0];
          need_d        = lay_disp;
          state_d       = (lay_disp != '0) ? ST_DISP : ST_IMM;
        end
        ST_DISP: begin
          if (need_q == DBW'(1))
            rec_d.disp = {{(DISP_W-8){in_byte[7]}}, in_byte};
          else
            rec_d.disp[{cnt_q, 3'b000} +: 8] = in_byte;
          cnt_d = cnt_q + CNT_W'(1);
          if (DBW'(cnt_q) + DBW'(1) == need_q) begin
            cnt_d   = '0;
            state_d = ST_IMM;
          end
        end
        default: begin
          rec_d.imm[{cnt_q, 3'b000} +: 8] = in_byte;
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == IMM_LAST) done = 1'b1;
        end
      endcase
      if (!done && err == ERR_NONE && len_n == LEN_MAX) err = ERR_LENGTH;
      if (done || err != ERR_NONE) begin
        rec_d.len = len_n;
        rec_d.err = done ? ERR_NONE : err;
        vld_d     = 1'b1;
        len_d     = '0;
        cnt_d     = '0;
        state_d   = ST_PFX;
      end else begin
        len_d = len_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PFX;
      rec_q   <= '0;
      vld_q   <= 1'b0;
      len_q   <= '0;
      cnt_q   <= '0;
      need_q  <= '0;
    end else begin
      if (take) begin
        state_q <= state_d;
        len_q   <= len_d;
        cnt_q   <= cnt_d;
        need_q  <= need_d;
      end
      if (take || fire) begin
        rec_q <= rec_d;
        vld_q <= vld_d;
      end
    end
  end

  assign out_valid         = vld_q;
  assign out_lock_rep      = rec_q.lock_rep;
  assign out_lock_rep_byte = rec_q.lock_rep_byte;
  assign out_seg_ovr       = rec_q.seg;
  assign out_seg_byte      = rec_q.seg_byte;
  assign out_opsize        = rec_q.opsize;
  assign out_addrsize      = rec_q.addrsize;
  assign out_rex_valid     = rec_q.rex;
  assign out_rex_bits      = rec_q.rex_bits;
  assign out_opcode        = rec_q.opcode;
  assign out_has_modrm     = rec_q.has_modrm;
  assign out_mod           = rec_q.mod;
  assign out_reg           = rec_q.reg_f;
  assign out_rm            = rec_q.rm;
  assign out_has_sib       = rec_q.has_sib;
  assign out_scale         = rec_q.scale;
  assign out_index         = rec_q.index;
  assign out_base          = rec_q.base;
  assign out_disp          = rec_q.disp;
  assign out_imm           = rec_q.imm;
  assign out_len           = rec_q.len;
  assign out_err           = rec_q.err;

  p_hold_record_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_opcode)
      && $stable(out_disp) && $stable(out_imm) && $stable(out_err));

  p_stall_input_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_len_bounds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0) && (out_len <= LEN_MAX));

  p_overlong_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err == 2'd3 |-> out_len == LEN_MAX);

  p_sib_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err == 2'd0 && out_has_sib |-> out_rm == 3'b100 && out_mod != 2'b11);

  p_return_bare_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err == 2'd0 && (out_opcode == OP_RET_NEAR || out_opcode == OP_RET_FAR)
      |-> !out_has_modrm && !out_has_sib && out_imm == '0);

  p_mov_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err == 2'd0 && out_opcode == OP_MOV_IMM |-> out_reg == 3'b000);
endmodule

// File: tb/insn_field_decoder_bench.sv
module insn_field_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode64 = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic out_ready = 1'b0;
  logic in_ready, out_valid;
  logic out_lock_rep, out_seg_ovr, out_opsize, out_addrsize, out_rex_valid;
  logic out_has_modrm, out_has_sib;
  logic [7:0] out_lock_rep_byte, out_seg_byte, out_opcode;
  logic [3:0] out_rex_bits, out_len;
  logic [1:0] out_mod, out_scale, out_err;
  logic [2:0] out_reg, out_rm, out_index, out_base;
  logic [31:0] out_disp, out_imm;

  always #5 clk = ~clk;

  insn_field_decoder u_insn_field_decoder (
    .clk(clk), .rst_n(rst_n), .mode64(mode64), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_lock_rep(out_lock_rep), .out_lock_rep_byte(out_lock_rep_byte),
    .out_seg_ovr(out_seg_ovr), .out_seg_byte(out_seg_byte), .out_opsize(out_opsize),
    .out_addrsize(out_addrsize), .out_rex_valid(out_rex_valid), .out_rex_bits(out_rex_bits),
    .out_opcode(out_opcode), .out_has_modrm(out_has_modrm), .out_mod(out_mod),
    .out_reg(out_reg), .out_rm(out_rm), .out_has_sib(out_has_sib), .out_scale(out_scale),
    .out_index(out_index), .out_base(out_base), .out_disp(out_disp), .out_imm(out_imm),
    .out_len(out_len), .out_err(out_err)
  );

  typedef struct {
    bit lr; bit [7:0] lrb; bit sg; bit [7:0] sgb; bit os; bit as_; bit rx; bit [3:0] rxb;
    bit [7:0] op; bit hm; bit [1:0] md; bit [2:0] rg; bit [2:0] rm; bit hs;
    bit [1:0] sc; bit [2:0] ix; bit [2:0] bs; bit [31:0] dp; bit [31:0] im;
    int len; int err;
  } exp_t;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] stim[$];
  exp_t ex;

  function automatic exp_t blank();
    exp_t e;
    e = '{default: '0};
    return e;
  endfunction

  function automatic int disp_size(bit [1:0] md, bit [2:0] rm, bit hs, bit [2:0] bs);
    if (md == 2'd1) return 1;
    if (md == 2'd2) return 4;
    if (md == 2'd3) return 0;
    if (hs) return (bs == 3'd5) ? 4 : 0;
    return (rm == 3'd5) ? 4 : 0;
  endfunction

  task automatic check(input string tag, input bit ok, input string act, input string expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, expv);
    end
  endtask

  task automatic send();
    foreach (stim[i]) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = stim[i];
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic check_rec(input string tag);
    string a, e;
    bit ok;
    if (ex.err != 0) begin
      ok = out_valid && out_err == ex.err[1:0] && out_len == ex.len[3:0];
      a = $sformatf("v=%0b err=%0d len=%0d", out_valid, out_err, out_len);
      e = $sformatf("v=1 err=%0d len=%0d", ex.err, ex.len);
    end else begin
      ok = out_valid && out_err == 2'd0 && out_len == ex.len[3:0] &&
           out_lock_rep == ex.lr && out_lock_rep_byte == ex.lrb && out_seg_ovr == ex.sg &&
           out_seg_byte == ex.sgb && out_opsize == ex.os && out_addrsize == ex.as_ &&
           out_rex_valid == ex.rx && out_rex_bits == ex.rxb && out_opcode == ex.op &&
           out_has_modrm == ex.hm && out_mod == ex.md && out_reg == ex.rg && out_rm == ex.rm &&
           out_has_sib == ex.hs && out_scale == ex.sc && out_index == ex.ix &&
           out_base == ex.bs && out_disp == ex.dp && out_imm == ex.im;
      a = $sformatf("v=%0b len=%0d op=%h pf=%b%b%b%b/%h/%h rex=%b/%h m=%b/%0d/%0d/%0d s=%b/%0d/%0d/%0d d=%h i=%h",
            out_valid, out_len, out_opcode, out_lock_rep, out_seg_ovr, out_opsize, out_addrsize,
            out_lock_rep_byte, out_seg_byte, out_rex_valid, out_rex_bits, out_has_modrm, out_mod,
            out_reg, out_rm, out_has_sib, out_scale, out_index, out_base, out_disp, out_imm);
      e = $sformatf("v=1 len=%0d op=%h pf=%b%b%b%b/%h/%h rex=%b/%h m=%b/%0d/%0d/%0d s=%b/%0d/%0d/%0d d=%h i=%h",
            ex.len, ex.op, ex.lr, ex.sg, ex.os, ex.as_, ex.lrb, ex.sgb, ex.rx, ex.rxb, ex.hm,
            ex.md, ex.rg, ex.rm, ex.hs, ex.sc, ex.ix, ex.bs, ex.dp, ex.im);
    end
    check(tag, ok, a, e);
    accept();
  endtask

  task automatic push32(input bit [31:0] v);
    for (int k = 0; k < 4; k++) stim.push_back(v[8*k +: 8]);
  endtask

  // Random legal instruction: prefixes in shuffled order, optional REX, then opcode fields.
  task automatic gen_random();
    logic [7:0] pf[$];
    logic [7:0] g1[3] = '{8'hF0, 8'hF2, 8'hF3};
    logic [7:0] g2[6] = '{8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65};
    logic [7:0] mr, sb, t;
    int dn, j, sel;
    stim.delete();
    ex = blank();
    mode64 = $urandom_range(0, 1) == 1;
    if ($urandom_range(0, 1) == 1) begin ex.lr = 1; ex.lrb = g1[$urandom_range(0, 2)]; pf.push_back(ex.lrb); end
    if ($urandom_range(0, 1) == 1) begin ex.sg = 1; ex.sgb = g2[$urandom_range(0, 5)]; pf.push_back(ex.sgb); end
    if ($urandom_range(0, 1) == 1) begin ex.os = 1; pf.push_back(8'h66); end
    if ($urandom_range(0, 1) == 1) begin ex.as_ = 1; pf.push_back(8'h67); end
    for (int k = pf.size() - 1; k > 0; k--) begin
      j = $urandom_range(0, k);
      t = pf[k]; pf[k] = pf[j]; pf[j] = t;
    end
    foreach (pf[k]) stim.push_back(pf[k]);
    sel = $urandom_range(0, 3);
    if (sel < 2) begin
      if (mode64 && $urandom_range(0, 1) == 1) begin
        ex.rx = 1; ex.rxb = 4'($urandom_range(0, 15)); stim.push_back({4'h4, ex.rxb});
      end
      ex.op = (sel == 0) ? 8'hC3 : 8'hCB;
      stim.push_back(ex.op);
    end else begin
      if (mode64 && stim.size() < 4 && $urandom_range(0, 1) == 1) begin
        ex.rx = 1; ex.rxb = 4'($urandom_range(0, 15)); stim.push_back({4'h4, ex.rxb});
      end
      ex.op = 8'hC7; ex.hm = 1;
      stim.push_back(8'hC7);
      ex.md = 2'($urandom_range(0, 3));
      ex.rm = 3'($urandom_range(0, 7));
      mr = {ex.md, 3'b000, ex.rm};
      stim.push_back(mr);
      if (ex.md != 2'd3 && ex.rm == 3'd4) begin
        sb = 8'($urandom);
        ex.hs = 1; ex.sc = sb[7:6]; ex.ix = sb[5:3]; ex.bs = sb[2:0];
        stim.push_back(sb);
      end
      dn = disp_size(ex.md, ex.rm, ex.hs, ex.bs);
      if (dn == 1) begin
        t = 8'($urandom);
        stim.push_back(t);
        ex.dp = {{24{t[7]}}, t};
      end else if (dn == 4) begin
        ex.dp = $urandom;
        push32(ex.dp);
      end
      ex.im = $urandom;
      push32(ex.im);
    end
    ex.len = stim.size();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 reset out_valid", out_valid == 1'b0, $sformatf("%0b", out_valid), "0");
    check("R12 reset in_ready", in_ready == 1'b1, $sformatf("%0b", in_ready), "1");
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 R7 R8: worked example
    mode64 = 1;
    stim = '{8'h67, 8'hC7, 8'h84, 8'h53, 8'h78, 8'h56, 8'h34, 8'h12, 8'hEF, 8'hBE, 8'hAD, 8'hDE};
    ex = blank(); ex.as_ = 1; ex.op = 8'hC7; ex.hm = 1; ex.md = 2; ex.rg = 0; ex.rm = 4;
    ex.hs = 1; ex.sc = 1; ex.ix = 2; ex.bs = 3; ex.dp = 32'h12345678; ex.im = 32'hDEADBEEF; ex.len = 12;
    send(); check_rec("R6 R8 worked example");

    // R1: near and far return, with a prefix
    stim = '{8'hC3}; ex = blank(); ex.op = 8'hC3; ex.len = 1;
    send(); check_rec("R1 near return");
    stim = '{8'hF3, 8'h2E, 8'hCB}; ex = blank(); ex.op = 8'hCB; ex.lr = 1; ex.lrb = 8'hF3;
    ex.sg = 1; ex.sgb = 8'h2E; ex.len = 3;
    send(); check_rec("R1 R2 far return with prefixes");

    // R3: duplicate group, second REX, legacy after REX
    stim = '{8'h66, 8'h66}; ex = blank(); ex.err = 2; ex.len = 2;
    send(); check_rec("R3 duplicate operand-size");
    stim = '{8'h26, 8'hF0, 8'h64}; ex = blank(); ex.err = 2; ex.len = 3;
    send(); check_rec("R3 duplicate segment");
    stim = '{8'h48, 8'h41}; ex = blank(); ex.err = 2; ex.len = 2;
    send(); check_rec("R3 second REX");
    stim = '{8'h48, 8'h67}; ex = blank(); ex.err = 2; ex.len = 2;
    send(); check_rec("R3 legacy after REX");
    stim = '{8'hC3}; ex = blank(); ex.op = 8'hC3; ex.len = 1;
    send(); check_rec("R3 resync after prefix error");

    // R4: REX gated by mode64
    stim = '{8'h4D, 8'hC3}; ex = blank(); ex.rx = 1; ex.rxb = 4'hD; ex.op = 8'hC3; ex.len = 2;
    send(); check_rec("R4 REX in 64-bit mode");
    mode64 = 0;
    stim = '{8'h48}; ex = blank(); ex.err = 1; ex.len = 1;
    send(); check_rec("R4 REX byte outside 64-bit mode");
    mode64 = 1;

    // R5: bad opcode extension; R9: unsupported opcode after a prefix
    stim = '{8'hC7, 8'h08}; ex = blank(); ex.err = 1; ex.len = 2;
    send(); check_rec("R5 nonzero Reg extension");
    stim = '{8'h2E, 8'h90}; ex = blank(); ex.err = 1; ex.len = 2;
    send(); check_rec("R9 unsupported opcode");

    // R7: displacement size corners
    stim = '{8'hC7, 8'h45, 8'hF0}; push32(32'h01020304);
    ex = blank(); ex.op = 8'hC7; ex.hm = 1; ex.md = 1; ex.rm = 5; ex.dp = 32'hFFFFFFF0;
    ex.im = 32'h01020304; ex.len = 7;
    send(); check_rec("R7 disp8 sign extension");
    stim = '{8'hC7, 8'h05}; push32(32'hCAFEF00D); push32(32'h00000011);
    ex = blank(); ex.op = 8'hC7; ex.hm = 1; ex.md = 0; ex.rm = 5; ex.dp = 32'hCAFEF00D;
    ex.im = 32'h11; ex.len = 10;
    send(); check_rec("R7 Mod00 RM101 disp32");
    stim = '{8'hC7, 8'h04, 8'h25}; push32(32'h80000001); push32(32'h7FFFFFFF);
    ex = blank(); ex.op = 8'hC7; ex.hm = 1; ex.rm = 4; ex.hs = 1; ex.sc = 0; ex.ix = 4; ex.bs = 5;
    ex.dp = 32'h80000001; ex.im = 32'h7FFFFFFF; ex.len = 11;
    send(); check_rec("R7 SIB base101 disp32");
    stim = '{8'hC7, 8'hC3}; push32(32'hA5A55A5A);
    ex = blank(); ex.op = 8'hC7; ex.hm = 1; ex.md = 3; ex.rm = 3; ex.im = 32'hA5A55A5A; ex.len = 6;
    send(); check_rec("R7 R8 register form no displacement");

    // R10: overlong instruction then resync
    stim = '{8'hF0, 8'h2E, 8'h66, 8'h67, 8'h41, 8'hC7, 8'h84, 8'h00,
             8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
    ex = blank(); ex.err = 3; ex.len = 15;
    send(); check_rec("R10 overlong instruction");
    stim = '{8'hCB}; ex = blank(); ex.op = 8'hCB; ex.len = 1;
    send(); check_rec("R10 next byte starts new instruction");

    // R11: stall while record is pending
    stim = '{8'hC3}; send();
    @(negedge clk); in_valid = 1'b1; in_byte = 8'hCB;
    repeat (3) @(negedge clk);
    check("R11 input stalled", in_ready == 1'b0 && out_valid == 1'b1,
          $sformatf("rdy=%0b v=%0b", in_ready, out_valid), "rdy=0 v=1");
    check("R11 record held", out_opcode == 8'hC3 && out_len == 4'd1,
          $sformatf("op=%h len=%0d", out_opcode, out_len), "op=c3 len=1");
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    ex = blank(); ex.op = 8'hCB; ex.len = 1;
    check_rec("R11 stalled byte taken after accept");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      gen_random();
      send();
      check_rec("R2 R7 R8 random instruction");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule